// File: doc/BRIEF.md
# Ordering Table Clear Channel

This block is a single-purpose DMA channel that prepares an empty, reverse-linked ordering table in RAM for a graphics pipeline. Software programs a start address and an entry count, then writes a trigger code to the control register. The channel walks downward from the start address and writes one 32-bit entry per word. Each entry points to the word directly below it. The lowest entry it writes holds an end-of-list marker, so later stages that link primitives into the table find a well-formed, empty chain.

The channel generates its data rather than copying it. It writes one entry per clock through a plain RAM write port and holds `busy` high for the whole fill. When it finishes, it clears the run bits of its control register and pulses `irq`. A control write with any value other than the trigger code is not supported: the channel writes nothing and completes at once with an interrupt. The walk never goes below RAM address zero.

Top module: `ordtab_clear_dma`

## Requirements
- R1: After reset, `busy`, `irq` and `memWe` are low, and all three registers read back as zero.
- R2: Register offsets are fixed. Offset 0 is the start address, which keeps bits ADDR_W-1:2; its low two bits and upper bits read as zero. Offset 1 is the entry count, which keeps the low CNT_W bits. Offset 2 is control. Offset 3 reads as zero. `regRdata` shows the selected register in the same cycle.
- R3: A fill starts only when control is written with exactly 0x11000002 while idle. `busy` is high from the cycle after that write.
- R4: A control write of any other value while idle writes nothing to RAM. It stores the value with bits 28 and 24 cleared and pulses `irq` for one cycle, starting the cycle after the write.
- R5: A fill writes one entry per cycle on consecutive cycles. The entries go to the start address, then start-4, start-8 and so on downward. `busy` and `memWe` are high exactly during those cycles.
- R6: Every entry except the last holds the byte address four below its own location, zero-extended into the low 24 bits, with bits 31:24 zero.
- R7: The last entry holds 0x00FFFFFF. With a count of N≥1 the fill writes N entries. A count of 0 writes only the marker, at the start address.
- R8: The walk never writes below address 0. If start/4+1 is less than the number of entries asked for, the fill writes start/4+1 entries and the marker lands at address 0.
- R9: In the cycle after the last entry, `busy` is low and `irq` is high for one cycle. Control then reads with bits 28 and 24 cleared, which gives 0x00000002 after a normal fill.
- R10: Register writes while `busy` is high have no effect: the fill does not change, and the address, count and control readbacks keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset (0 address, 1 count, 2 control) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Readback of the selected register |
| memWe | output | 1 | RAM write enable |
| memAddr | output | ADDR_W | RAM byte address of the entry being written |
| memWdata | output | 32 | Entry value |
| busy | output | 1 | High while the table is being filled |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A wrong walk cursor shows at once on `memAddr`. The link value in `memWdata` disagrees with its own address on that same write cycle, so the error is visible on the first bad entry. A wrong remaining count or a missed base-of-RAM stop shows as the marker arriving one or more cycles early or late: `busy` and `irq` then change in a cycle other than the one computed from start and count. A control register left with stale run bits shows on the readback taken right after `irq`.

// File: rtl/ordtab_pkg.sv
package ordtab_pkg;
  localparam logic [31:0] START_CODE = 32'h1100_0002;
  localparam logic [31:0] RUN_BITS   = 32'h1100_0000;
  localparam logic [31:0] END_MARK   = 32'h00FF_FFFF;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic load;    // latch cursor and remaining, store control
    logic step;    // write one entry this cycle
    logic finish;  // current entry is the last one
    logic reject;  // unsupported control code
  } otcStrobes_t;
endpackage

// File: rtl/ordtab_ctrl.sv
module ordtab_ctrl
  import ordtab_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  input  logic        lastEntry,
  output otcStrobes_t strb,
  output logic        busy,
  output logic        irq
);
  typedef enum logic {ST_IDLE, ST_FILL} state_e;
  state_e state;
  logic ctrlWrite;

  assign ctrlWrite = regWe && (regSel_e'(regAddr) == SEL_CTRL);
  assign busy = (state == ST_FILL);

  always_comb begin
    strb = '0;
    if (state == ST_IDLE) begin
      if (ctrlWrite) begin
        strb.load   = (regWdata == START_CODE);
        strb.reject = (regWdata != START_CODE);
      end
    end else begin
      strb.step   = 1'b1;
      strb.finish = lastEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      irq <= strb.finish | strb.reject;
      if (strb.load) state <= ST_FILL;
      else if (strb.finish) state <= ST_IDLE;
    end
  end

  // R9
  busy_fall_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  // R5
  fill_continues_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastEntry) |=> busy);
endmodule

// File: rtl/ordtab_datapath.sv
module ordtab_datapath
  import ordtab_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  otcStrobes_t       strb,
  input  logic              busy,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              lastEntry,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata
);
  localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] startAddr, cursor, below;
  logic [CNT_W-1:0]  countReg, remaining;
  logic [31:0]       ctrlReg;
  logic              idleWrite;

  assign idleWrite = regWe && !busy;
  assign lastEntry = (remaining <= CNT_W'(1)) || (cursor == '0);
  assign below     = cursor - WORD_STEP;

  assign memWe    = strb.step;
  assign memAddr  = cursor;
  assign memWdata = lastEntry ? END_MARK : {{(32-ADDR_W){1'b0}}, below};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      countReg  <= '0;
      ctrlReg   <= '0;
      cursor    <= '0;
      remaining <= '0;
    end else begin
      if (idleWrite && regSel_e'(regAddr) == SEL_ADDR)
        startAddr <= regWdata[ADDR_W-1:0] & ALIGN_MASK;
      if (idleWrite && regSel_e'(regAddr) == SEL_COUNT)
        countReg <= regWdata[CNT_W-1:0];
      if (strb.load) begin
        ctrlReg   <= regWdata;
        cursor    <= startAddr;
        remaining <= countReg;
      end else if (strb.reject) begin
        ctrlReg <= regWdata & ~RUN_BITS;
      end
      if (strb.step && !lastEntry) begin
        cursor    <= below;
        remaining <= remaining - CNT_W'(1);
      end
      if (strb.finish)
        ctrlReg <= ctrlReg & ~RUN_BITS;
    end
  end

  always_comb begin
    case (regSel_e'(regAddr))
      SEL_ADDR:  regRdata = {{(32-ADDR_W){1'b0}}, startAddr};
      SEL_COUNT: regRdata = {{(32-CNT_W){1'b0}}, countReg};
      SEL_CTRL:  regRdata = ctrlReg;
      default:   regRdata = '0;
    endcase
  end

  // R5
  descend_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !lastEntry) |=> (memAddr == $past(memAddr) - WORD_STEP));

  // R9
  run_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (ctrlReg[28] == 1'b0 && ctrlReg[24] == 1'b0));

  // R8
  within_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr <= startAddr));

  // R4
  reject_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> !memWe);
endmodule

// File: rtl/ordtab_clear_dma.sv
module ordtab_clear_dma
  import ordtab_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              busy,
  output logic              irq
);
  otcStrobes_t strb;
  logic lastEntry;

  ordtab_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .lastEntry(lastEntry), .strb(strb),
    .busy(busy), .irq(irq)
  );

  ordtab_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .lastEntry(lastEntry), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata)
  );
endmodule

// File: tb/ordtab_clear_dma_tb.sv
module ordtab_clear_dma_tb;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 16;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata, memWdata;
  logic memWe, busy, irq;
  logic [ADDR_W-1:0] memAddr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ordtab_clear_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .busy(busy), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic finishSummary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Expected-entry check for entry i of a fill with m entries from start s.
  task automatic checkEntry(input int s, input int i, input int m);
    int a = s - 4 * i;
    logic [31:0] expData = (i == m - 1) ? 32'h00FF_FFFF : 32'(a - 4);
    check("R5 busy",   {31'b0, busy},  32'd1);
    check("R5 memWe",  {31'b0, memWe}, 32'd1);
    check("R5 addr",   {20'b0, memAddr}, 32'(a));
    check((i == m - 1) ? "R7 marker" : "R6 link", memWdata, expData);
  endtask

  task automatic runFill(input int s, input int n);
    logic [31:0] rd;
    int m = (n == 0) ? 1 : n;
    if (m > s / 4 + 1) m = s / 4 + 1;   // R8 base-of-RAM stop
    regWrite(2'd0, 32'(s));
    regWrite(2'd1, 32'(n));
    check("R3 idle before start", {31'b0, busy}, 32'd0);
    regWrite(2'd2, 32'h1100_0002);
    for (int i = 0; i < m; i++) begin
      checkEntry(s, i, m);
      @(negedge clk);
    end
    check("R9 busy low", {31'b0, busy}, 32'd0);
    check("R9 irq",      {31'b0, irq},  32'd1);
    check("R9 no write", {31'b0, memWe}, 32'd0);
    regRead(2'd2, rd);
    check("R9 ctrl cleared", rd, 32'h0000_0002);
    @(negedge clk);
    check("R9 irq one cycle", {31'b0, irq}, 32'd0);
  endtask

  task automatic rejectCode(input logic [31:0] code);
    logic [31:0] rd;
    regWrite(2'd2, code);
    check("R4 irq",   {31'b0, irq},   32'd1);
    check("R4 idle",  {31'b0, busy},  32'd0);
    check("R4 no write", {31'b0, memWe}, 32'd0);
    regRead(2'd2, rd);
    check("R4 stored", rd, code & ~32'h1100_0000);
    @(negedge clk);
    check("R4 pulse ends", {31'b0, irq}, 32'd0);
    check("R4 still no write", {31'b0, memWe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishSummary();
  end

  initial begin
    logic [31:0] rd;
    int starts [6] = '{0, 4, 8, 12, 20, 4092};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy",  {31'b0, busy},  32'd0);
    check("R1 irq",   {31'b0, irq},   32'd0);
    check("R1 memWe", {31'b0, memWe}, 32'd0);
    for (int r = 0; r < 4; r++) begin
      regRead(2'(r), rd);
      check("R1 reg zero", rd, 32'd0);
    end

    // R2 field widths and offsets
    regWrite(2'd0, 32'h1234_5677);
    regRead(2'd0, rd); check("R2 addr mask", rd, 32'h0000_0674);
    regWrite(2'd1, 32'hABCD_1234);
    regRead(2'd1, rd); check("R2 count mask", rd, 32'h0000_1234);
    regWrite(2'd3, 32'hFFFF_FFFF);
    regRead(2'd3, rd); check("R2 offset 3", rd, 32'd0);

    // R4 unsupported codes
    rejectCode(32'h0100_0201);
    rejectCode(32'h1100_0003);
    rejectCode(32'hFFFF_FFFF);

    // R5 R6 R7 R8 sweep over starts and counts
    foreach (starts[k])
      for (int n = 0; n <= 6; n++)
        runFill(starts[k], n);
    // R8 large count truncated at base
    runFill(32'h674, 32'h1234);

    // R10 writes during a fill are ignored
    regWrite(2'd0, 32'h200);
    regWrite(2'd1, 32'd4);
    regWrite(2'd2, 32'h1100_0002);
    checkEntry(32'h200, 0, 4);
    regWe = 1'b1; regAddr = 2'd0; regWdata = 32'h40;
    @(negedge clk);
    regAddr = 2'd1; regWdata = 32'd1;
    checkEntry(32'h200, 1, 4);
    @(negedge clk);
    regAddr = 2'd2; regWdata = 32'h0100_0201;
    checkEntry(32'h200, 2, 4);
    @(negedge clk);
    regWe = 1'b0;
    checkEntry(32'h200, 3, 4);
    @(negedge clk);
    check("R10 done on time", {31'b0, irq}, 32'd1);
    regRead(2'd0, rd); check("R10 addr kept", rd, 32'h200);
    regRead(2'd1, rd); check("R10 count kept", rd, 32'd4);
    regRead(2'd2, rd); check("R10 ctrl", rd, 32'h0000_0002);
    @(negedge clk);
    check("R10 no restart", {31'b0, busy}, 32'd0);

    finishSummary();
  end
endmodule